// File: doc/BRIEF.md
# Interrupt Mask and Level Controller

This block gathers up to 64 interrupt request lines. It keeps one mask bit per source and a programmable priority level per source. From these it drives a single interrupt line toward the processor core, together with the level of the strongest request that may currently interrupt. Software changes the mask through two byte-wide write ports. One port sets a bit and the other clears it, so no read-modify-write sequence is needed. Each port also has an "all bits" flag. When both ports are written in the same cycle, the set port wins and the clear write is dropped.

An acknowledge request returns a vector for the winning source. When the automatic level masking feature is enabled, the acknowledge also loads the current level mask with the winner's level. The value the current level mask held just before is kept in a saved level register, so a service routine can restore it afterwards. Software may also write the current level mask directly, for example to lower it and then poll for pending work with further acknowledges.

The acknowledge sequencer is a three-state machine:
- ST_IDLE waits for a request.
- ST_RESOLVE captures the winner.
- ST_RESPOND presents the vector for one cycle and applies the level mask update.

The transitions are:
- IDLE to RESOLVE on an acknowledge request.
- RESOLVE to RESPOND unconditionally.
- RESPOND to IDLE unconditionally.

Requests that arrive outside ST_IDLE are dropped.

Top module: `irq_mask_level_ctrl`

## Requirements
- R1: After reset, every mask bit is 1, the current and saved level masks are 0, every source level is 0, automatic masking is off and `irq_o` is 0.
- R2: A write to the set port with bit 6 low sets the mask bit whose index is in bits 5:0. With bit 6 high it sets all mask bits. Bit 7 has no effect.
- R3: A write to the clear port with bit 6 low clears the mask bit whose index is in bits 5:0. With bit 6 high it clears all mask bits and the index is ignored.
- R4: When the set and clear ports are written in the same cycle, only the set write takes effect and the clear write is discarded.
- R5: Register addresses 0x8 (set port) and 0x9 (clear port) always read as 0x00.
- R6: `irq_o` and `irq_lvl_o` are registered. They reflect the state one clock earlier, and `irq_lvl_o` is the highest level among sources that are pending, unmasked, at a nonzero level and above the current level mask. When no source qualifies, both are 0.
- R7: An acknowledge request taken in ST_IDLE raises `ack_valid_o` for one cycle, two clocks later. `ack_vec_o` is then 64 plus the index of the qualifying source with the highest level, with ties going to the lowest index.
- R8: With automatic masking on (bit 0 of address 0xC), a successful acknowledge loads the current level mask (address 0xA) with the winner's level and copies its former value into the saved level mask (address 0xB).
- R9: With automatic masking off, an acknowledge leaves both level mask registers unchanged.
- R10: When no source qualifies at capture, the acknowledge returns vector 24 and leaves both level mask registers unchanged.
- R11: Software writes to address 0xA set the current level mask directly. The new value governs both `irq_o` and later acknowledges.
- R12: Address 0xD selects a source index. Address 0xE writes and reads that source's 3-bit level. Mask byte k reads at address k, with source 8k+j in bit j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_src_i | input | NUM_SRC | Request lines, one per source |
| set_we_i | input | 1 | Set-port write strobe |
| set_data_i | input | 8 | Set-port byte: index in 5:0, set-all in bit 6 |
| clr_we_i | input | 1 | Clear-port write strobe |
| clr_data_i | input | 8 | Clear-port byte: index in 5:0, clear-all in bit 6 |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| ack_req_i | input | 1 | Acknowledge request pulse |
| ack_valid_o | output | 1 | Vector valid (ST_RESPOND) |
| ack_vec_o | output | 8 | Acknowledge vector |
| irq_o | output | 1 | Interrupt toward the core |
| irq_lvl_o | output | LVL_W | Level of the strongest qualifying request |

## Verification
The bench builds the block with its defaults: 64 sources, 3-bit levels, vector base 64 and spurious vector 24. These widths are small enough to sweep every set and clear index across the whole mask, and to program and read back every source's level. The bench also steps the current level mask through all eight values against a full set of pending requests. Several arithmetically generated level and pending patterns test the winner choice, including ties, and nested automatic acknowledges exercise the save and restore of the level masks.

// File: rtl/imlc_pkg.sv
package imlc_pkg;
    localparam logic [3:0] A_SET = 4'h8;
    localparam logic [3:0] A_CLR = 4'h9;
    localparam logic [3:0] A_CUR = 4'hA;
    localparam logic [3:0] A_SAV = 4'hB;
    localparam logic [3:0] A_CFG = 4'hC;
    localparam logic [3:0] A_SEL = 4'hD;
    localparam logic [3:0] A_LVL = 4'hE;
    localparam int ALL_BIT = 6;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RESOLVE = 2'd1,
        ST_RESPOND = 2'd2
    } ack_state_e;
endpackage

// File: rtl/imlc_mask_bank.sv
module imlc_mask_bank #(
    parameter int NUM_SRC = 64,
    parameter int IDX_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_we,
    input  logic [7:0]         set_data,
    input  logic               clr_we,
    input  logic [7:0]         clr_data,
    output logic [NUM_SRC-1:0] mask_o
);
    import imlc_pkg::*;

    logic [NUM_SRC-1:0] mask_q, mask_d;
    logic [IDX_W-1:0]   set_idx, clr_idx;

    assign set_idx = set_data[IDX_W-1:0];
    assign clr_idx = clr_data[IDX_W-1:0];

    // Set port has priority: a same-cycle clear is dropped.
    always_comb begin
        mask_d = mask_q;
        if (set_we) begin
            if (set_data[ALL_BIT])
                mask_d = '1;
            else if (32'(set_idx) < NUM_SRC)
                mask_d[set_idx] = 1'b1;
        end else if (clr_we) begin
            if (clr_data[ALL_BIT])
                mask_d = '0;
            else if (32'(clr_idx) < NUM_SRC)
                mask_d[clr_idx] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= '1;
        else        mask_q <= mask_d;
    end

    assign mask_o = mask_q;

    assert_set_all_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we && set_data[ALL_BIT]) |=> (&mask_q));

    assert_clear_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && clr_data[ALL_BIT] && !set_we) |=> (mask_q == '0));

    assert_pair_no_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we && clr_we) |=> ($countones(mask_q) >= $countones($past(mask_q))));
endmodule

// File: rtl/imlc_level_table.sv
module imlc_level_table #(
    parameter int NUM_SRC = 64,
    parameter int LVL_W   = 3,
    parameter int IDX_W   = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sel_we,
    input  logic                     lvl_we,
    input  logic [7:0]               wdata,
    output logic [IDX_W-1:0]         sel_o,
    output logic [LVL_W-1:0]         sel_lvl_o,
    output logic [NUM_SRC*LVL_W-1:0] lvl_flat_o
);
    logic [IDX_W-1:0] sel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sel_q <= '0;
        else if (sel_we) sel_q <= wdata[IDX_W-1:0];
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_lvl
        logic [LVL_W-1:0] lvl_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                lvl_q <= '0;
            else if (lvl_we && (sel_q == IDX_W'(g)))
                lvl_q <= wdata[LVL_W-1:0];
        end
        assign lvl_flat_o[g*LVL_W +: LVL_W] = lvl_q;
    end

    assign sel_o     = sel_q;
    assign sel_lvl_o = lvl_flat_o[32'(sel_q)*LVL_W +: LVL_W];

    assert_levels_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !lvl_we |=> $stable(lvl_flat_o));
endmodule

// File: rtl/imlc_pick.sv
module imlc_pick #(
    parameter int NUM_SRC = 64,
    parameter int LVL_W   = 3,
    parameter int IDX_W   = 6
) (
    input  logic [NUM_SRC-1:0]       pend,
    input  logic [NUM_SRC-1:0]       mask,
    input  logic [NUM_SRC*LVL_W-1:0] lvl_flat,
    input  logic [LVL_W-1:0]         floor_lvl,
    output logic                     hit,
    output logic [IDX_W-1:0]         win_idx,
    output logic [LVL_W-1:0]         win_lvl
);
    logic [LVL_W-1:0] lv;

    // Strictly greater keeps the lowest index on a tie.
    always_comb begin
        hit     = 1'b0;
        win_idx = '0;
        win_lvl = '0;
        lv      = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            lv = lvl_flat[i*LVL_W +: LVL_W];
            if (pend[i] && !mask[i] && (lv > floor_lvl) && (lv > win_lvl)) begin
                hit     = 1'b1;
                win_idx = IDX_W'(i);
                win_lvl = lv;
            end
        end
    end
endmodule

// File: rtl/irq_mask_level_ctrl.sv
module irq_mask_level_ctrl #(
    parameter int NUM_SRC  = 64,
    parameter int LVL_W    = 3,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 64,
    parameter int SPUR_VEC = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_src_i,
    input  logic               set_we_i,
    input  logic [7:0]         set_data_i,
    input  logic               clr_we_i,
    input  logic [7:0]         clr_data_i,
    input  logic               reg_we_i,
    input  logic [3:0]         reg_addr_i,
    input  logic [7:0]         reg_wdata_i,
    output logic [7:0]         reg_rdata_o,
    input  logic               ack_req_i,
    output logic               ack_valid_o,
    output logic [VEC_W-1:0]   ack_vec_o,
    output logic               irq_o,
    output logic [LVL_W-1:0]   irq_lvl_o
);
    import imlc_pkg::*;

    localparam int IDX_W      = $clog2(NUM_SRC);
    localparam int MASK_BYTES = NUM_SRC / 8;

    ack_state_e state_q, state_d;

    logic [NUM_SRC-1:0]       mask_q;
    logic [NUM_SRC*LVL_W-1:0] lvl_flat;
    logic [IDX_W-1:0]         sel_idx;
    logic [LVL_W-1:0]         sel_lvl;
    logic [LVL_W-1:0]         cur_q, sav_q;
    logic                     auto_en;
    logic                     pick_hit;
    logic [IDX_W-1:0]         pick_idx;
    logic [LVL_W-1:0]         pick_lvl;
    logic                     cap_hit;
    logic [LVL_W-1:0]         cap_lvl;
    logic [VEC_W-1:0]         cap_vec;
    logic                     cur_wr;

    assign cur_wr = reg_we_i && (reg_addr_i == A_CUR);

    imlc_mask_bank #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_we   (set_we_i),
        .set_data (set_data_i),
        .clr_we   (clr_we_i),
        .clr_data (clr_data_i),
        .mask_o   (mask_q)
    );

    imlc_level_table #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_lvl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_we     (reg_we_i && (reg_addr_i == A_SEL)),
        .lvl_we     (reg_we_i && (reg_addr_i == A_LVL)),
        .wdata      (reg_wdata_i),
        .sel_o      (sel_idx),
        .sel_lvl_o  (sel_lvl),
        .lvl_flat_o (lvl_flat)
    );

    imlc_pick #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_pick (
        .pend      (irq_src_i),
        .mask      (mask_q),
        .lvl_flat  (lvl_flat),
        .floor_lvl (cur_q),
        .hit       (pick_hit),
        .win_idx   (pick_idx),
        .win_lvl   (pick_lvl)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (ack_req_i) state_d = ST_RESOLVE;
            ST_RESOLVE: state_d = ST_RESPOND;
            ST_RESPOND: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Winner capture in ST_RESOLVE
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_hit <= 1'b0;
            cap_lvl <= '0;
            cap_vec <= VEC_W'(SPUR_VEC);
        end else if (state_q == ST_RESOLVE) begin
            cap_hit <= pick_hit;
            cap_lvl <= pick_lvl;
            cap_vec <= pick_hit ? VEC_W'(VEC_BASE + 32'(pick_idx)) : VEC_W'(SPUR_VEC);
        end
    end

    // Level mask registers: the acknowledge update beats a software write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
            sav_q <= '0;
        end else if ((state_q == ST_RESPOND) && cap_hit && auto_en) begin
            sav_q <= cur_q;
            cur_q <= cap_lvl;
        end else if (cur_wr) begin
            cur_q <= reg_wdata_i[LVL_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               auto_en <= 1'b0;
        else if (reg_we_i && reg_addr_i == A_CFG) auto_en <= reg_wdata_i[0];
    end

    // Registered interrupt outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_o     <= 1'b0;
            irq_lvl_o <= '0;
        end else begin
            irq_o     <= pick_hit;
            irq_lvl_o <= pick_hit ? pick_lvl : '0;
        end
    end

    // Output decode
    always_comb begin
        ack_valid_o = 1'b0;
        ack_vec_o   = cap_vec;
        unique case (state_q)
            ST_RESPOND: ack_valid_o = 1'b1;
            default:    ack_valid_o = 1'b0;
        endcase
    end

    always_comb begin
        reg_rdata_o = 8'h00;
        if (32'(reg_addr_i) < MASK_BYTES) begin
            reg_rdata_o = mask_q[32'(reg_addr_i)*8 +: 8];
        end else begin
            case (reg_addr_i)
                A_CUR:   reg_rdata_o = 8'(cur_q);
                A_SAV:   reg_rdata_o = 8'(sav_q);
                A_CFG:   reg_rdata_o = {7'd0, auto_en};
                A_SEL:   reg_rdata_o = 8'(sel_idx);
                A_LVL:   reg_rdata_o = 8'(sel_lvl);
                default: reg_rdata_o = 8'h00;
            endcase
        end
    end

    assert_irq_above_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (irq_lvl_o > $past(cur_q)));

    assert_ack_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && ack_req_i) |=> ##1 ack_valid_o);

    assert_ack_saves_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid_o && cap_hit && auto_en) |=> (sav_q == $past(cur_q)));

    assert_noauto_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid_o && !auto_en && !cur_wr) |=> ($stable(cur_q) && $stable(sav_q)));

    assert_spurious_vec_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid_o && !cap_hit) |-> (ack_vec_o == VEC_W'(SPUR_VEC)));
endmodule

// File: tb/sim_irq_mask_level_ctrl.sv
`timescale 1ns/1ps
module sim_irq_mask_level_ctrl;
    localparam int N = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] irq_src = '0;
    logic        set_we = 0, clr_we = 0, reg_we = 0, ack_req = 0;
    logic [7:0]  set_data = 0, clr_data = 0, reg_wdata = 0;
    logic [3:0]  reg_addr = 0;
    logic [7:0]  reg_rdata;
    logic        ack_valid, irq_o;
    logic [7:0]  ack_vec;
    logic [2:0]  irq_lvl;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    logic [N-1:0] m_mask;
    int m_lvl [N];
    int m_cur, m_sav;
    bit m_auto;

    always #2 clk = ~clk;

    irq_mask_level_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .irq_src_i(irq_src),
        .set_we_i(set_we), .set_data_i(set_data),
        .clr_we_i(clr_we), .clr_data_i(clr_data),
        .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata), .ack_req_i(ack_req),
        .ack_valid_o(ack_valid), .ack_vec_o(ack_vec),
        .irq_o(irq_o), .irq_lvl_o(irq_lvl)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; #0.5; d = reg_rdata;
    endtask

    task automatic ports(input bit s, input logic [7:0] sd, input bit c, input logic [7:0] cd);
        @(negedge clk); set_we = s; set_data = sd; clr_we = c; clr_data = cd;
        @(negedge clk); set_we = 0; clr_we = 0;
        if (s) begin
            if (sd[6]) m_mask = '1; else m_mask[sd[5:0]] = 1'b1;
        end else if (c) begin
            if (cd[6]) m_mask = '0; else m_mask[cd[5:0]] = 1'b0;
        end
    endtask

    task automatic chk_mask(input string tag);
        logic [7:0] d;
        for (int b = 0; b < N/8; b++) begin
            rd(4'(b), d);
            chk(tag, d, m_mask[8*b +: 8]);
        end
    endtask

    task automatic set_lvl(input int i, input int v);
        wr(4'hD, 8'(i)); wr(4'hE, 8'(v)); m_lvl[i] = v;
    endtask

    function automatic int winner(output int wl);
        int best = -1;
        wl = 0;
        for (int i = 0; i < N; i++)
            if (irq_src[i] && !m_mask[i] && m_lvl[i] > m_cur && m_lvl[i] > wl) begin
                best = i; wl = m_lvl[i];
            end
        return best;
    endfunction

    task automatic chk_irq(input string tag);
        int wl, w;
        repeat (2) @(negedge clk);
        #0.5;
        w = winner(wl);
        chk({tag, " irq_o"}, irq_o, (w >= 0));
        chk({tag, " irq_lvl"}, irq_lvl, wl);
    endtask

    task automatic do_ack(input string tag);
        int wl, w;
        logic [7:0] d;
        w = winner(wl);
        @(negedge clk); ack_req = 1;
        @(negedge clk); ack_req = 0;
        @(negedge clk); #0.5;
        chk({tag, " valid"}, ack_valid, 1);
        chk({tag, " vec"}, ack_vec, (w >= 0) ? 64 + w : 24);
        if (w >= 0 && m_auto) begin m_sav = m_cur; m_cur = wl; end
        rd(4'hA, d); chk({tag, " cur"}, d, m_cur);
        rd(4'hB, d); chk({tag, " sav"}, d, m_sav);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        m_mask = '1; m_cur = 0; m_sav = 0; m_auto = 0;
        for (int i = 0; i < N; i++) m_lvl[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        chk_mask("R1 mask");
        rd(4'hA, d); chk("R1 cur", d, 0);
        rd(4'hB, d); chk("R1 sav", d, 0);
        rd(4'hC, d); chk("R1 cfg", d, 0);
        rd(4'hE, d); chk("R1 lvl0", d, 0);
        chk("R1 irq", irq_o, 0);

        // R3 clear-all, then R2/R3 single-index sweep
        ports(0, 0, 1, 8'h45); chk_mask("R3 clear-all");
        for (int i = 0; i < N; i++) begin
            ports(1, 8'h80 | 8'(i), 0, 0); chk_mask("R2 set idx");
            ports(0, 0, 1, 8'(i));         chk_mask("R3 clr idx");
        end
        ports(1, 8'h40, 0, 0); chk_mask("R2 set-all");
        ports(0, 0, 1, 8'h40 | 8'd5); chk_mask("R3 clr-all ignores idx");

        // R4 simultaneous writes
        ports(1, 8'd3, 1, 8'd3);  chk_mask("R4 same idx");
        ports(1, 8'd10, 1, 8'd3); chk_mask("R4 other idx");
        ports(1, 8'd20, 1, 8'h40); chk_mask("R4 clr-all dropped");

        // R5 write-only ports read zero
        rd(4'h8, d); chk("R5 set port read", d, 0);
        rd(4'h9, d); chk("R5 clr port read", d, 0);

        // R12 level table sweep
        for (int i = 0; i < N; i++) set_lvl(i, (i*3 + 1) % 8);
        for (int i = 0; i < N; i++) begin
            wr(4'hD, 8'(i)); rd(4'hE, d); chk("R12 level readback", d, m_lvl[i]);
        end

        // R6 / R11 floor sweep with all pending and all unmasked
        ports(0, 0, 1, 8'h40);
        @(negedge clk); irq_src = '1;
        for (int c = 0; c < 8; c++) begin
            wr(4'hA, 8'(c)); m_cur = c; chk_irq("R6 R11 floor sweep");
        end
        wr(4'hA, 0); m_cur = 0;
        @(negedge clk); irq_src = '0; chk_irq("R6 none pending");

        // R7 / R9 winner patterns, automatic masking off
        for (int k = 0; k < 8; k++) begin
            logic [N-1:0] p;
            for (int i = 0; i < N; i++) begin
                set_lvl(i, (i*(2*k + 3) + k) % 8);
                p[i] = ((i*7 + k) % 5) != 0;
            end
            ports(0, 0, 1, 8'h40);
            ports(1, 8'(k*5), 0, 0);
            @(negedge clk); irq_src = p;
            chk_irq("R6 pattern");
            do_ack("R7 R9 pattern");
        end

        // R7 tie goes to lowest index
        for (int i = 0; i < N; i++) if (m_lvl[i] != 0) set_lvl(i, 1);
        set_lvl(40, 4); set_lvl(9, 4);
        ports(0, 0, 1, 8'h40);
        @(negedge clk); irq_src = '0; irq_src[40] = 1; irq_src[9] = 1;
        do_ack("R7 tie");
        chk("R7 tie vector", ack_vec, 64 + 9);

        // R8 / R11 nested automatic acknowledges and restore
        wr(4'hC, 1); m_auto = 1;
        set_lvl(5, 5); set_lvl(3, 3); set_lvl(7, 7);
        @(negedge clk); irq_src = '0; irq_src[5] = 1; irq_src[3] = 1; irq_src[7] = 1;
        do_ack("R8 first");
        chk_irq("R8 blocked at top level");
        wr(4'hA, 8'(m_sav)); m_cur = m_sav;
        chk_irq("R11 restore");
        wr(4'hA, 4); m_cur = 4;
        do_ack("R8 R11 poll from 4");
        do_ack("R8 nothing above");
        wr(4'hA, 0); m_cur = 0;
        ports(1, 8'd7, 0, 0);
        do_ack("R8 masked top source");

        // R10 spurious
        @(negedge clk); irq_src = '0;
        do_ack("R10 spurious");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule